// File: doc/BRIEF.md
# Dynamic Width External Bus Controller

This block runs the external memory cycles of a small 16-bit processor core over a multiplexed address/data bus. The core raises a request with an address, a read/write flag, a byte/word flag and an instruction-fetch flag. The block first decides whether the address belongs to the on-chip program region. If it does not, the block runs one or two bus cycles. Each cycle has an address phase followed by a data phase. When the whole access is finished, the block returns a single completion pulse and, for reads, the assembled data.

The width of each bus cycle can be fixed at 8 bits, or it can be taken from an external width pin that is sampled during every address phase. A word access that lands on an 8-bit cycle is split into two byte cycles. The address strobe pin works in one of two modes. In the first it is a short latch pulse. In the second it is an active-low address-valid signal that stays low for the whole cycle, so that memories can use it directly as a chip select.

The on-chip region covers `ONCHIP_LO` to `ONCHIP_HI`. It is active only when the external-access pin was high while reset was held. Requests that fall in the region are flagged to the core and produce no bus activity.

Top module: `ext_bus_ctrl`

## Requirements
- R1: With `cfg_dyn_width` = 1, `bus_width_pin` is sampled during the address phase. A value of 1 makes the cycle 16 bits wide and a value of 0 makes it 8 bits wide.
- R2: With `cfg_dyn_width` = 0, every external cycle is 8 bits wide, whatever the value of `bus_width_pin`.
- R3: A word access on an 8-bit cycle becomes two byte cycles. The first uses address A and the second uses A+1, with one idle clock between them. The low byte moves in the first cycle and the high byte in the second, and `done` pulses only once, after the second cycle.
- R4: With `cfg_strobe_valid` = 0, `as_pin` is high during the single address-phase clock and low at all other times.
- R5: With `cfg_strobe_valid` = 1, `as_pin` is low from the address phase through the end of the cycle, including the write hold clock. It is high when idle and during the gap between split halves.
- R6: A request that falls in the on-chip region raises `req_onchip`. It causes no strobe, no bus drive and no `done`.
- R7: `ext_access_pin` is captured while `rst_n` is low. When the captured value is 1, addresses 2000H through 3FFFH inclusive are on-chip. When it is 0, every address is off-chip. Changes to the pin after reset have no effect.
- R8: `inst` is high during the address and data phases of an external read that has `req_fetch` = 1. It is low at all other times, including writes.
- R9: The address phase lasts one clock, with `ad_oe` = 1 and `ad_out` set to the cycle's address. It is followed by a data phase with `rd_n` or `wr_n` low. The data phase lasts one clock plus one clock for each cycle in which `ready_pin` is sampled low.
- R10: A read captures `ad_in` at the clock edge where `rd_n` rises. On a 16-bit cycle at an odd address the byte is taken from bits 15:8. On all other byte cycles it is taken from bits 7:0. A word read on a 16-bit cycle takes the whole bus. Byte reads return the byte zero-extended.
- R11: During a write data phase, `ad_out` carries the whole word on a 16-bit word cycle. Otherwise it carries the current byte on both lanes. `ad_oe` and `ad_out` are held for one clock after `wr_n` rises.
- R12: `done` is a one-clock pulse in the clock after the last data phase or write hold ends. A request still present while `done` is high is not started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_dyn_width | input | 1 | 1: take each cycle's width from the width pin |
| cfg_strobe_valid | input | 1 | 1: address strobe is an active-low valid signal; 0: latch pulse |
| ext_access_pin | input | 1 | External-access select, captured during reset |
| req_valid | input | 1 | Core request, held until `done` |
| req_addr | input | 16 | Request address |
| req_write | input | 1 | 1: write |
| req_word | input | 1 | 1: word access, 0: byte access |
| req_fetch | input | 1 | Request is an instruction fetch |
| req_wdata | input | 16 | Write data |
| req_onchip | output | 1 | Request targets the on-chip region |
| done | output | 1 | Access complete pulse |
| rd_data | output | 16 | Assembled read data |
| bus_width_pin | input | 1 | Per-cycle width select (1 = 16 bits) |
| ready_pin | input | 1 | Data phase ends when this is sampled high |
| as_pin | output | 1 | Address strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inst | output | 1 | Instruction-fetch indicator |
| ad_out | output | 16 | Multiplexed bus, driven value |
| ad_oe | output | 1 | Bus output enable |
| ad_in | input | 16 | Multiplexed bus, received value |

## Verification
A sequencer stuck in the wrong phase shows up within one clock as a wrong combination of `as_pin`, `rd_n`, `wr_n` and `ad_oe`. An off-by-one in the ready stall shows up as a strobe that rises a clock early or late. A wrong width decision is a delayed symptom. It appears only later, as a missing or extra second byte cycle, a wrong `ad_out` lane pattern, or a wrongly assembled `rd_data` at the `done` pulse. A wrong captured external-access value becomes visible only when an address in the program region is requested, as a mismatch between `req_onchip` and bus activity.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_DATA = 3'd2,
    PH_HOLD = 3'd3,
    PH_GAP  = 3'd4
  } ebc_phase_e;
endpackage

// File: rtl/ebc_region_dec.sv
module ebc_region_dec #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] LO = 'h2000,
  parameter logic [ADDR_W-1:0] HI = 'h3FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_access_pin,
  input  logic [ADDR_W-1:0] addr,
  output logic              onchip
);
  logic ea_q;

  function automatic logic in_window(input logic [ADDR_W-1:0] a);
    return (a >= LO) && (a <= HI);
  endfunction

  // Captured only while reset is held; frozen afterwards.
  always_ff @(posedge clk) begin
    if (!rst_n) ea_q <= ext_access_pin;
  end

  assign onchip = ea_q && in_window(addr);
endmodule

// File: rtl/ebc_width_sel.sv
module ebc_width_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_dyn_width,
  input  logic bus_width_pin,
  input  logic sample,
  output logic cyc16
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cyc16 <= 1'b0;
    else if (sample) cyc16 <= cfg_dyn_width & bus_width_pin;
  end
endmodule

// File: rtl/ebc_cycle_seq.sv
module ebc_cycle_seq
  import ebc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_strobe_valid,
  input  logic              start_ok,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_word,
  input  logic              req_fetch,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              cyc16,
  input  logic              ready_pin,
  input  logic [DATA_W-1:0] ad_in,
  output logic              addr_phase,
  output logic              data_phase,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              as_pin,
  output logic              rd_n,
  output logic              wr_n,
  output logic              inst,
  output logic [ADDR_W-1:0] ad_out,
  output logic              ad_oe
);
  localparam int BYTE_W = DATA_W / 2;

  ebc_phase_e        ph_q;
  logic [ADDR_W-1:0] base_q;
  logic [DATA_W-1:0] wdata_q;
  logic [BYTE_W-1:0] low_q;
  logic              wr_q, word_q, fetch_q, half2_q;

  function automatic logic [BYTE_W-1:0] pick_lane(input logic [DATA_W-1:0] bus,
                                                  input logic wide, input logic odd);
    return (wide && odd) ? bus[DATA_W-1:BYTE_W] : bus[BYTE_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] write_drive(input logic [DATA_W-1:0] wd,
                                                    input logic wide, input logic word,
                                                    input logic second);
    logic [BYTE_W-1:0] b;
    b = second ? wd[DATA_W-1:BYTE_W] : wd[BYTE_W-1:0];
    return (wide && word && !second) ? wd : {b, b};
  endfunction

  logic [ADDR_W-1:0] cur_addr;
  logic [BYTE_W-1:0] cap_byte;
  logic              need_split, in_cycle;

  assign cur_addr   = half2_q ? base_q + 1'b1 : base_q;
  assign cap_byte   = pick_lane(ad_in, cyc16, cur_addr[0]);
  assign need_split = word_q && !half2_q && !cyc16;
  assign addr_phase = (ph_q == PH_ADDR);
  assign data_phase = (ph_q == PH_DATA);
  assign in_cycle   = addr_phase || data_phase || (ph_q == PH_HOLD);
  assign busy       = (ph_q != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      base_q  <= '0;
      wdata_q <= '0;
      low_q   <= '0;
      wr_q    <= 1'b0;
      word_q  <= 1'b0;
      fetch_q <= 1'b0;
      half2_q <= 1'b0;
      done    <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      unique case (ph_q)
        PH_IDLE: if (req_valid && start_ok && !done) begin
          base_q  <= req_addr;
          wdata_q <= req_wdata;
          wr_q    <= req_write;
          word_q  <= req_word;
          fetch_q <= req_fetch;
          half2_q <= 1'b0;
          ph_q    <= PH_ADDR;
        end
        PH_ADDR: ph_q <= PH_DATA;
        PH_DATA: if (ready_pin) begin
          if (wr_q) begin
            ph_q <= PH_HOLD;
          end else if (need_split) begin
            low_q   <= cap_byte;
            half2_q <= 1'b1;
            ph_q    <= PH_GAP;
          end else begin
            if (word_q && half2_q)   rd_data <= {cap_byte, low_q};
            else if (word_q)         rd_data <= ad_in;
            else                     rd_data <= {{(DATA_W-BYTE_W){1'b0}}, cap_byte};
            done <= 1'b1;
            ph_q <= PH_IDLE;
          end
        end
        PH_HOLD: if (need_split) begin
          half2_q <= 1'b1;
          ph_q    <= PH_GAP;
        end else begin
          done <= 1'b1;
          ph_q <= PH_IDLE;
        end
        PH_GAP:  ph_q <= PH_ADDR;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    as_pin = cfg_strobe_valid ? !in_cycle : addr_phase;
    rd_n   = !(data_phase && !wr_q);
    wr_n   = !(data_phase && wr_q);
    inst   = fetch_q && !wr_q && (addr_phase || data_phase);
    ad_oe  = addr_phase || (wr_q && (data_phase || ph_q == PH_HOLD));
    if (addr_phase) ad_out = cur_addr;
    else if (wr_q && in_cycle)
      ad_out = ADDR_W'(write_drive(wdata_q, cyc16, word_q, half2_q));
    else ad_out = '0;
  end
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] ONCHIP_LO = 'h2000,
  parameter logic [ADDR_W-1:0] ONCHIP_HI = 'h3FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_dyn_width,
  input  logic              cfg_strobe_valid,
  input  logic              ext_access_pin,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_word,
  input  logic              req_fetch,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_onchip,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  input  logic              bus_width_pin,
  input  logic              ready_pin,
  output logic              as_pin,
  output logic              rd_n,
  output logic              wr_n,
  output logic              inst,
  output logic [ADDR_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_in
);
  logic hit_w, cyc16_w, addr_phase_w, data_phase_w, busy_w;

  ebc_region_dec #(.ADDR_W(ADDR_W), .LO(ONCHIP_LO), .HI(ONCHIP_HI)) u_region (
    .clk(clk), .rst_n(rst_n), .ext_access_pin(ext_access_pin),
    .addr(req_addr), .onchip(hit_w)
  );

  ebc_width_sel u_width (
    .clk(clk), .rst_n(rst_n), .cfg_dyn_width(cfg_dyn_width),
    .bus_width_pin(bus_width_pin), .sample(addr_phase_w), .cyc16(cyc16_w)
  );

  ebc_cycle_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg_strobe_valid(cfg_strobe_valid),
    .start_ok(!hit_w), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_word(req_word), .req_fetch(req_fetch),
    .req_wdata(req_wdata), .cyc16(cyc16_w), .ready_pin(ready_pin), .ad_in(ad_in),
    .addr_phase(addr_phase_w), .data_phase(data_phase_w), .busy(busy_w),
    .done(done), .rd_data(rd_data), .as_pin(as_pin), .rd_n(rd_n), .wr_n(wr_n),
    .inst(inst), .ad_out(ad_out), .ad_oe(ad_oe)
  );

  assign req_onchip = req_valid && hit_w;
endmodule

// File: rtl/ebc_checker.sv
module ebc_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_dyn_width,
  input logic              cfg_strobe_valid,
  input logic              bus_width_pin,
  input logic              req_onchip,
  input logic              busy,
  input logic              addr_phase,
  input logic              data_phase,
  input logic              cyc16,
  input logic              done,
  input logic              as_pin,
  input logic              rd_n,
  input logic              wr_n,
  input logic              inst,
  input logic              ad_oe,
  input logic [ADDR_W-1:0] ad_out
);
  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  // R4
  latch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_strobe_valid && as_pin) |-> (rd_n && wr_n && ad_oe));
  // R11
  write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> (ad_oe && ad_out == $past(ad_out)));
  // R6
  onchip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_onchip && !busy) |-> (!ad_oe && rd_n && wr_n));
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  fetch_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inst |-> (wr_n && (addr_phase || data_phase)));
  // R2
  fixed_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_phase && !cfg_dyn_width) |-> !cyc16);
  // R1
  width_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_phase && cfg_dyn_width && bus_width_pin) |=> cyc16);
endmodule

bind ext_bus_ctrl ebc_checker #(.ADDR_W(ADDR_W)) u_ebc_checker (
  .clk(clk), .rst_n(rst_n), .cfg_dyn_width(cfg_dyn_width),
  .cfg_strobe_valid(cfg_strobe_valid), .bus_width_pin(bus_width_pin),
  .req_onchip(req_onchip), .busy(busy_w), .addr_phase(addr_phase_w),
  .data_phase(data_phase_w), .cyc16(cyc16_w), .done(done), .as_pin(as_pin),
  .rd_n(rd_n), .wr_n(wr_n), .inst(inst), .ad_oe(ad_oe), .ad_out(ad_out)
);

// File: tb/ext_bus_ctrl_bench.sv
`timescale 1ns/1ps
module ext_bus_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_dyn_width = 1'b1, cfg_strobe_valid = 1'b0, ext_access_pin = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0, req_fetch = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0, ad_in = '0;
  logic bus_width_pin = 1'b0, ready_pin = 1'b1;
  logic req_onchip, done, as_pin, rd_n, wr_n, inst, ad_oe;
  logic [15:0] rd_data, ad_out;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  ext_bus_ctrl u_ext_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_dyn_width(cfg_dyn_width),
    .cfg_strobe_valid(cfg_strobe_valid), .ext_access_pin(ext_access_pin),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .req_word(req_word), .req_fetch(req_fetch), .req_wdata(req_wdata),
    .req_onchip(req_onchip), .done(done), .rd_data(rd_data),
    .bus_width_pin(bus_width_pin), .ready_pin(ready_pin), .as_pin(as_pin),
    .rd_n(rd_n), .wr_n(wr_n), .inst(inst), .ad_out(ad_out), .ad_oe(ad_oe),
    .ad_in(ad_in)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Expected pins for a bench phase: 0 idle, 1 address, 2 data, 3 write hold, 4 gap
  task automatic pins(input int ph, input bit wr, input bit fetch,
                      input logic [15:0] bus, input string req);
    bit e_as, e_rd, e_wr, e_oe, e_in;
    e_as = cfg_strobe_valid ? !(ph >= 1 && ph <= 3) : (ph == 1);
    e_rd = !(ph == 2 && !wr);
    e_wr = !(ph == 2 && wr);
    e_oe = (ph == 1) || (wr && (ph == 2 || ph == 3));
    e_in = fetch && !wr && (ph == 1 || ph == 2);
    chk(as_pin == e_as, {req, " strobe R4/R5"}, as_pin, e_as);
    chk({rd_n, wr_n} == {e_rd, e_wr}, {req, " rd/wr R9"}, {rd_n, wr_n}, {e_rd, e_wr});
    chk(ad_oe == e_oe, {req, " oe R9/R11"}, ad_oe, e_oe);
    chk(inst == e_in, {req, " inst R8"}, inst, e_in);
    if (e_oe) chk(ad_out == bus, {req, " bus R9/R11"}, ad_out, bus);
  endtask

  task automatic bus_cycle(input logic [15:0] a, input bit wr, input bit fetch,
                           input bit wpin, input int stall, input logic [15:0] rbus,
                           input logic [15:0] wbus, input string req);
    @(negedge clk);
    pins(1, wr, fetch, a, req);
    bus_width_pin = wpin;
    for (int k = 0; k <= stall; k++) begin
      @(negedge clk);
      pins(2, wr, fetch, wbus, req);
      ready_pin = (k == stall);
      ad_in = (k == stall) ? rbus : 16'hDEAD;
    end
    if (wr) begin
      @(negedge clk);
      pins(3, wr, fetch, wbus, req);
    end
    ready_pin = 1'b1;
  endtask

  task automatic access(input logic [15:0] a, input bit wr, input bit word,
                        input bit fetch, input logic [15:0] wd, input bit w1,
                        input bit w2, input int stall, input logic [15:0] bus1,
                        input logic [15:0] bus2, input logic [15:0] exp_rd,
                        input string req);
    bit wide1, split;
    logic [15:0] wb1, wb2;
    wide1 = cfg_dyn_width && w1;
    split = word && !wide1;
    wb1 = (word && wide1) ? wd : {wd[7:0], wd[7:0]};
    wb2 = {wd[15:8], wd[15:8]};
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_word = word;
    req_fetch = fetch; req_wdata = wd;
    bus_cycle(a, wr, fetch, w1, stall, bus1, wb1, req);
    if (split) begin
      @(negedge clk);
      pins(4, wr, fetch, 16'h0, {req, " gap R3"});
      chk(done == 1'b0, {req, " no early done R3"}, done, 1'b0);
      bus_cycle(a + 16'd1, wr, fetch, w2, 0, bus2, wb2, req);
    end
    @(negedge clk);
    chk(done == 1'b1, {req, " done R12"}, done, 1'b1);
    if (!wr) chk(rd_data == exp_rd, {req, " read data R10"}, rd_data, exp_rd);
    @(negedge clk);
    chk(done == 1'b0, {req, " single done R12"}, done, 1'b0);
    pins(0, wr, fetch, 16'h0, {req, " no restart R12"});
    req_valid = 1'b0;
  endtask

  task automatic do_reset(input bit ea);
    rst_n = 1'b0; ext_access_pin = ea;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset(1'b1);
    @(negedge clk);
    pins(0, 1'b0, 1'b0, 16'h0, "reset R4");
    chk(done == 1'b0, "reset done R12", done, 1'b0);
    // R1 R10 R8: 16-bit fetch word read
    access(16'h4000, 0, 1, 1, 16'h0, 1, 0, 0, 16'hBEEF, 16'h0, 16'hBEEF, "R1 wide read");
    // R1 R3 R10: first half narrow, second half wide at odd address
    access(16'h4010, 0, 1, 0, 16'h0, 0, 1, 0, 16'h1234, 16'hAB00, 16'hAB34, "R3 split read");
    // R9 R11: wide word write with two ready stalls
    access(16'h5000, 1, 1, 0, 16'hCAFE, 1, 0, 2, 16'h0, 16'h0, 16'h0, "R11 wide write");
    // R10: byte read at odd address on a 16-bit cycle
    access(16'h5001, 0, 0, 0, 16'h0, 1, 0, 0, 16'h7700, 16'h0, 16'h0077, "R10 odd byte");
    // R11: byte write on an 8-bit cycle
    access(16'h5002, 1, 0, 0, 16'h00A5, 0, 0, 0, 16'h0, 16'h0, 16'h0, "R11 byte write");
    // R7: region boundaries with captured high
    req_addr = 16'h1FFF; req_valid = 1'b1; #1;
    chk(req_onchip == 1'b0, "R7 below region", req_onchip, 1'b0);
    req_addr = 16'h4000; #1;
    chk(req_onchip == 1'b0, "R7 above region", req_onchip, 1'b0);
    req_addr = 16'h3FFF; #1;
    chk(req_onchip == 1'b1, "R7 top of region", req_onchip, 1'b1);
    ext_access_pin = 1'b0;
    req_addr = 16'h2000; #1;
    chk(req_onchip == 1'b1, "R7 pin change ignored", req_onchip, 1'b1);
    // R6: on-chip request leaves the bus quiet
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      pins(0, 1'b0, 1'b0, 16'h0, "R6 on-chip quiet");
      chk(done == 1'b0, "R6 no done", done, 1'b0);
    end
    req_valid = 1'b0;
    // R2 R5: fixed narrow, valid-mode strobe, width pin high ignored
    cfg_dyn_width = 1'b0; cfg_strobe_valid = 1'b1;
    @(negedge clk);
    pins(0, 1'b0, 1'b0, 16'h0, "R5 idle high");
    access(16'h6000, 1, 1, 0, 16'h3412, 1, 1, 0, 16'h0, 16'h0, 16'h0, "R2 split write");
    access(16'h6100, 0, 1, 1, 16'h0, 1, 1, 1, 16'h0056, 16'h9978, 16'h7856, "R2 split fetch");
    // R7: captured low sends the program region off-chip
    do_reset(1'b0);
    @(negedge clk);
    req_addr = 16'h2100; req_valid = 1'b1; #1;
    chk(req_onchip == 1'b0, "R7 captured low", req_onchip, 1'b0);
    req_valid = 1'b0;
    access(16'h2100, 0, 0, 0, 16'h0, 1, 0, 1, 16'h0042, 16'h0, 16'h0042, "R7 off-chip byte");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule